// File: doc/BRIEF.md
# Dataway Command Decoder for a Multi-Channel Converter Module

This block sits between a crate dataway and the acquisition logic of a converter module with up to four channels and an optional threshold comparator. Each strobed cycle carries a function code, a subaddress and, for writes, a data word. The block decodes the pair and carries out the command. It answers with read data and with the command-accepted (X) and response (Q) bits.

The block holds four pieces of state: the four writable control bits, the comparator/gain word, the attention enable and the test-mode state. It also holds the per-channel data registers. The acquisition sequencer loads those registers, and a single test command can load all of them at once. The sequencer supplies the data-ready flag and the comparator verdict, and it receives a one-cycle restart pulse. That pulse fires when the command just accepted is the restart command that the control bits select.

Configuration inputs state which channels are fitted and whether the comparator is fitted. Commands aimed at absent hardware are refused.

Top module: `dataway_cmd_decoder`

## Requirements
- R1: After reset, x_o, q_o, rdata_o, restart_o, unit_reset_o, cmp_o, gl_o, cont_o, test_mode_o and lam_o are 0, and every data register reads 0.
- R2: Function 0 at subaddress n (0..3) reads channel n+1 when it is fitted, with X=1 and Q=flag_i. rdata_o carries the register when Q=1 and 0 when Q=0. Every response appears in the cycle after the strobe edge.
- R3: Function 1 at subaddress 0 returns X=1 and Q=1, with rdata_o[5:0] = {stop_i, flag_i, sel[1], sel[0], cont, gl} and the upper bits 0.
- R4: Function 17 at subaddress 0 loads wdata_i[3:0] into the control bits: bit0 is greater-than select, bit1 is continuous mode, bits 3:2 are the restart select. It returns X=1 and Q=1 whatever the flag.
- R5: Function 16 at subaddress 0 with the comparator fitted returns X=1 and Q=flag_i. When the flag is set it loads cmp_o from wdata_i, and gain_o equals the low four bits (bit0 is channel 1, 1 is high gain). When the flag is clear, cmp_o stays unchanged.
- R6: Function 26 and function 24 at subaddress 0 set and clear the attention enable, with X=1 and Q=0. Function 27 at subaddress 0 returns Q=enable. Function 8 at subaddress 15 returns Q=enable AND flag_i. lam_o is enable AND flag_i at all times.
- R7: Function 16 at subaddress 15 writes wdata_i into every data register, sets test_mode_o, and returns X=1 and Q=1. While test mode is set, sequencer stores are ignored.
- R8: Function 25 at subaddress 15 clears cmp_o and test mode and pulses unit_reset_o for one cycle, with X=1 and Q=0.
- R9: A read of an unfitted channel, function 16 at subaddress 0 with no comparator, and every undefined function/subaddress pair return X=0, Q=0 and rdata_o=0, and change no state.
- R10: restart_o pulses for one cycle when the accepted command (Q=1) matches the restart select: 0 selects function 16 at subaddress 0, 1 selects read of channel 1, 2 selects read of channel 2, 3 selects read of channel 4.
- R11: Outside test mode, store_i loads each channel register from its DW-bit slice of store_data_i (channel 1 in the lowest slice).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strobe_i | input | 1 | One-cycle command strobe |
| func_i | input | 5 | Function code |
| sub_i | input | 4 | Subaddress |
| wdata_i | input | 12 | Write data |
| chan_fit_i | input | 4 | Channel fitted mask, bit0 = channel 1 |
| cmp_fit_i | input | 1 | Comparator fitted |
| flag_i | input | 1 | Data-ready flag from sequencer |
| stop_i | input | 1 | Comparator verdict from sequencer |
| store_i | input | 1 | Sequencer store of conversion results |
| store_data_i | input | 48 | Conversion results, channel 1 lowest |
| rdata_o | output | 12 | Read data |
| x_o | output | 1 | Command accepted |
| q_o | output | 1 | Response bit |
| lam_o | output | 1 | Attention request |
| cmp_o | output | 12 | Comparator threshold |
| gain_o | output | 4 | Per-channel high-gain selects |
| gl_o | output | 1 | Greater-than select |
| cont_o | output | 1 | Continuous mode select |
| test_mode_o | output | 1 | Test mode active |
| restart_o | output | 1 | Restart pulse to sequencer |
| unit_reset_o | output | 1 | Unit reset pulse to sequencer |

## Verification
Every one of the 512 function/subaddress pairs is driven under two fitting configurations. The first has all hardware present. The second lacks channels 2 and 3 and the comparator. The X and Q bits are compared with a table built in the bench, which separates defined from undefined pairs and fitted from unfitted targets. Directed sequences then repeat each data, comparator and restart command with the flag set and then cleared, to separate Q qualification from acceptance. Every restart select is tried against every candidate command. Broadcast and store data use distinct values per channel, so that a misrouted slice or a store leaking into test mode shows up.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

    localparam int F_READ     = 0;
    localparam int F_RD_CTRL  = 1;
    localparam int F_TST_LAM  = 8;
    localparam int F_WRITE    = 16;
    localparam int F_WR_CTRL  = 17;
    localparam int F_LAM_OFF  = 24;
    localparam int F_RESET    = 25;
    localparam int F_LAM_ON   = 26;
    localparam int F_TST_EN   = 27;

    localparam int CTRL_W     = 4;

    typedef enum logic [3:0] {
        CMD_NONE,
        CMD_RD_DATA,
        CMD_RD_CTRL,
        CMD_TST_LAM,
        CMD_WR_CMP,
        CMD_WR_TEST,
        CMD_WR_CTRL,
        CMD_LAM_OFF,
        CMD_LAM_ON,
        CMD_TST_EN,
        CMD_RESET
    } cmd_e;

endpackage

// File: rtl/dwc_decode.sv
module dwc_decode
    import dwc_pkg::*;
#(
    parameter int NCH = 4,
    parameter int FW  = 5,
    parameter int AW  = 4,
    localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [FW-1:0]  func,
    input  logic [AW-1:0]  sub,
    input  logic [NCH-1:0] chan_fit,
    input  logic           cmp_fit,
    output cmd_e           cmd,
    output logic [CIW-1:0] chan
);

    localparam logic [AW-1:0] SUB_TOP  = {AW{1'b1}};
    localparam logic [AW-1:0] SUB_ZERO = '0;

    logic sub_is_chan;

    always_comb begin
        sub_is_chan = (32'(sub) < NCH);
        chan        = sub[CIW-1:0];
    end

    always_comb begin
        cmd = CMD_NONE;
        if (func == FW'(F_READ)) begin
            if (sub_is_chan && chan_fit[chan]) cmd = CMD_RD_DATA;
        end else if (func == FW'(F_RD_CTRL)) begin
            if (sub == SUB_ZERO) cmd = CMD_RD_CTRL;
        end else if (func == FW'(F_TST_LAM)) begin
            if (sub == SUB_TOP) cmd = CMD_TST_LAM;
        end else if (func == FW'(F_WRITE)) begin
            if (sub == SUB_ZERO && cmp_fit) cmd = CMD_WR_CMP;
            else if (sub == SUB_TOP)        cmd = CMD_WR_TEST;
        end else if (func == FW'(F_WR_CTRL)) begin
            if (sub == SUB_ZERO) cmd = CMD_WR_CTRL;
        end else if (func == FW'(F_LAM_OFF)) begin
            if (sub == SUB_ZERO) cmd = CMD_LAM_OFF;
        end else if (func == FW'(F_LAM_ON)) begin
            if (sub == SUB_ZERO) cmd = CMD_LAM_ON;
        end else if (func == FW'(F_TST_EN)) begin
            if (sub == SUB_ZERO) cmd = CMD_TST_EN;
        end else if (func == FW'(F_RESET)) begin
            if (sub == SUB_TOP) cmd = CMD_RESET;
        end
    end

endmodule

// File: rtl/dwc_bank.sv
module dwc_bank #(
    parameter int NCH = 4,
    parameter int DW  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_en,
    input  logic [NCH*DW-1:0] store_data,
    input  logic              bcast_en,
    input  logic [DW-1:0]     bcast_data,
    output logic [NCH*DW-1:0] words
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [DW-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (bcast_en)      word_d = bcast_data;
            else if (store_en) word_d = store_data[ch*DW +: DW];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end

        assign words[ch*DW +: DW] = word_q;

        assert_store_slice_R11: assert property (@(posedge clk) disable iff (!rst_n)
            store_en && !bcast_en |=> word_q == $past(store_data[ch*DW +: DW]));
        assert_bcast_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
            bcast_en |=> word_q == $past(bcast_data));
    end

endmodule

// File: rtl/dataway_cmd_decoder.sv
module dataway_cmd_decoder
    import dwc_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 12,
    parameter int FW  = 5,
    parameter int AW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [FW-1:0]     func_i,
    input  logic [AW-1:0]     sub_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [NCH-1:0]    chan_fit_i,
    input  logic              cmp_fit_i,
    input  logic              flag_i,
    input  logic              stop_i,
    input  logic              store_i,
    input  logic [NCH*DW-1:0] store_data_i,
    output logic [DW-1:0]     rdata_o,
    output logic              x_o,
    output logic              q_o,
    output logic              lam_o,
    output logic [DW-1:0]     cmp_o,
    output logic [NCH-1:0]    gain_o,
    output logic              gl_o,
    output logic              cont_o,
    output logic              test_mode_o,
    output logic              restart_o,
    output logic              unit_reset_o
);

    localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [DW-1:0]     cmp;
        logic              lam_en;
        logic              test;
        logic              x;
        logic              q;
        logic [DW-1:0]     rdata;
        logic              restart;
        logic              ureset;
    } state_t;

    state_t s_d, s_q;

    cmd_e              cmd;
    logic [CIW-1:0]    chan;
    logic [NCH*DW-1:0] words;
    logic              store_en;
    logic              bcast_en;
    logic [1:0]        sel;

    dwc_decode #(.NCH(NCH), .FW(FW), .AW(AW)) i_decode (
        .func     (func_i),
        .sub      (sub_i),
        .chan_fit (chan_fit_i),
        .cmp_fit  (cmp_fit_i),
        .cmd      (cmd),
        .chan     (chan)
    );

    dwc_bank #(.NCH(NCH), .DW(DW)) i_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .store_en   (store_en),
        .store_data (store_data_i),
        .bcast_en   (bcast_en),
        .bcast_data (wdata_i),
        .words      (words)
    );

    assign sel = s_q.ctrl[3:2];

    function automatic logic read_is_restart(input logic [1:0] s, input logic [CIW-1:0] c);
        case (s)
            2'd1:    return 32'(c) == 0;
            2'd2:    return 32'(c) == 1;
            2'd3:    return 32'(c) == 3;
            default: return 1'b0;
        endcase
    endfunction

    always_comb begin
        s_d         = s_q;
        s_d.x       = 1'b0;
        s_d.q       = 1'b0;
        s_d.rdata   = '0;
        s_d.restart = 1'b0;
        s_d.ureset  = 1'b0;
        bcast_en    = 1'b0;
        store_en    = store_i && !s_q.test;
        if (strobe_i) begin
            case (cmd)
                CMD_RD_DATA: begin
                    s_d.x = 1'b1;
                    s_d.q = flag_i;
                    if (flag_i) begin
                        s_d.rdata   = words[32'(chan)*DW +: DW];
                        s_d.restart = read_is_restart(sel, chan);
                    end
                end
                CMD_RD_CTRL: begin
                    s_d.x     = 1'b1;
                    s_d.q     = 1'b1;
                    s_d.rdata = DW'({stop_i, flag_i, s_q.ctrl});
                end
                CMD_TST_LAM: begin
                    s_d.x = 1'b1;
                    s_d.q = s_q.lam_en && flag_i;
                end
                CMD_WR_CMP: begin
                    s_d.x = 1'b1;
                    s_d.q = flag_i;
                    if (flag_i) begin
                        s_d.cmp     = wdata_i;
                        s_d.restart = (sel == 2'd0);
                    end
                end
                CMD_WR_TEST: begin
                    s_d.x    = 1'b1;
                    s_d.q    = 1'b1;
                    s_d.test = 1'b1;
                    bcast_en = 1'b1;
                end
                CMD_WR_CTRL: begin
                    s_d.x    = 1'b1;
                    s_d.q    = 1'b1;
                    s_d.ctrl = wdata_i[CTRL_W-1:0];
                end
                CMD_LAM_OFF: begin
                    s_d.x      = 1'b1;
                    s_d.lam_en = 1'b0;
                end
                CMD_LAM_ON: begin
                    s_d.x      = 1'b1;
                    s_d.lam_en = 1'b1;
                end
                CMD_TST_EN: begin
                    s_d.x = 1'b1;
                    s_d.q = s_q.lam_en;
                end
                CMD_RESET: begin
                    s_d.x      = 1'b1;
                    s_d.cmp    = '0;
                    s_d.test   = 1'b0;
                    s_d.ureset = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata_o      = s_q.rdata;
    assign x_o          = s_q.x;
    assign q_o          = s_q.q;
    assign lam_o        = s_q.lam_en && flag_i;
    assign cmp_o        = s_q.cmp;
    assign gain_o       = s_q.cmp[NCH-1:0];
    assign gl_o         = s_q.ctrl[0];
    assign cont_o       = s_q.ctrl[1];
    assign test_mode_o  = s_q.test;
    assign restart_o    = s_q.restart;
    assign unit_reset_o = s_q.ureset;

    assert_q_implies_x_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q_o |-> x_o);
    assert_restart_accepted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> q_o && x_o);
    assert_reset_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i && func_i == FW'(F_RESET) && sub_i == {AW{1'b1}}
        |=> cmp_o == '0 && !test_mode_o && unit_reset_o && x_o && !q_o);
    assert_cmp_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i && func_i == FW'(F_WRITE) && sub_i == '0 && !flag_i
        |=> $stable(cmp_o) && !q_o);
    assert_ctrl_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i && func_i == FW'(F_WR_CTRL) && sub_i == '0
        |=> q_o && gl_o == $past(wdata_i[0]) && cont_o == $past(wdata_i[1]));
    assert_no_x_no_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !x_o |-> rdata_o == '0);
    assert_lam_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i && func_i == FW'(F_LAM_ON) && sub_i == '0 |=> lam_o == flag_i && !q_o);

endmodule

// File: tb/test_dataway_cmd_decoder.sv
module test_dataway_cmd_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0;
    logic [4:0]  func = '0;
    logic [3:0]  sub = '0;
    logic [11:0] wdata = '0;
    logic [3:0]  chan_fit = 4'hF;
    logic        cmp_fit = 1'b1;
    logic        flag = 1'b0;
    logic        stop = 1'b0;
    logic        store = 1'b0;
    logic [47:0] store_data = '0;
    logic [11:0] rdata, cmp;
    logic        x, q, lam, gl, cont, test_mode, restart, ureset;
    logic [3:0]  gain;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dataway_cmd_decoder i_dataway_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .func_i(func), .sub_i(sub),
        .wdata_i(wdata), .chan_fit_i(chan_fit), .cmp_fit_i(cmp_fit), .flag_i(flag),
        .stop_i(stop), .store_i(store), .store_data_i(store_data), .rdata_o(rdata),
        .x_o(x), .q_o(q), .lam_o(lam), .cmp_o(cmp), .gain_o(gain), .gl_o(gl),
        .cont_o(cont), .test_mode_o(test_mode), .restart_o(restart), .unit_reset_o(ureset)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cmd(input int f, input int a, input int w);
        @(negedge clk);
        strobe = 1'b1;
        func   = f[4:0];
        sub    = a[3:0];
        wdata  = w[11:0];
        @(negedge clk);
        strobe = 1'b0;
    endtask

    task automatic do_store(input logic [47:0] d);
        @(negedge clk);
        store      = 1'b1;
        store_data = d;
        @(negedge clk);
        store = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic int exp_x(input int f, input int a, input logic [3:0] fit, input logic cf);
        case (f)
            0:              return (a < 4 && fit[a]) ? 1 : 0;
            1, 17, 24, 26, 27: return (a == 0) ? 1 : 0;
            8, 25:          return (a == 15) ? 1 : 0;
            16:             return ((a == 0 && cf) || a == 15) ? 1 : 0;
            default:        return 0;
        endcase
    endfunction

    function automatic logic [47:0] pattern(input int seed);
        logic [47:0] p;
        for (int c = 0; c < 4; c++) p[c*12 +: 12] = 12'((seed + 1) * 12'h111 + c * 12'h25 + c);
        return p;
    endfunction

    initial begin
        #1ms;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [47:0] pat;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 x", int'(x), 0);           chk("R1 q", int'(q), 0);
        chk("R1 rdata", int'(rdata), 0);   chk("R1 cmp", int'(cmp), 0);
        chk("R1 gl", int'(gl), 0);         chk("R1 cont", int'(cont), 0);
        chk("R1 test", int'(test_mode), 0); chk("R1 lam", int'(lam), 0);
        chk("R1 restart", int'(restart), 0); chk("R1 ureset", int'(ureset), 0);
        rst_n = 1'b1;
        flag = 1'b1;
        for (int c = 0; c < 4; c++) begin
            cmd(0, c, 0);
            chk("R1 data zero", int'(rdata), 0);
        end

        // R9: sweep all pairs under two fitting configurations
        for (int cfg = 0; cfg < 2; cfg++) begin
            chan_fit = (cfg == 0) ? 4'hF : 4'b1001;
            cmp_fit  = (cfg == 0);
            flag     = 1'b0;
            for (int f = 0; f < 32; f++) begin
                for (int a = 0; a < 16; a++) begin
                    cmd(f, a, 0);
                    chk($sformatf("R9 x f%0d a%0d", f, a), int'(x), exp_x(f, a, chan_fit, cmp_fit));
                    if (exp_x(f, a, chan_fit, cmp_fit) == 0)
                        chk("R9 q undefined", int'(q), 0);
                end
            end
            do_reset();
        end
        chan_fit = 4'hF;
        cmp_fit  = 1'b1;

        // R11 and R2: store then read with and without flag
        pat = pattern(3);
        do_store(pat);
        flag = 1'b1;
        for (int c = 0; c < 4; c++) begin
            cmd(0, c, 0);
            chk("R2 x", int'(x), 1);
            chk("R2 q flag set", int'(q), 1);
            chk("R11 read data", int'(rdata), int'(pat[c*12 +: 12]));
        end
        flag = 1'b0;
        cmd(0, 2, 0);
        chk("R2 q flag clear", int'(q), 0);
        chk("R2 x flag clear", int'(x), 1);
        chk("R2 rdata when q clear", int'(rdata), 0);

        // R4 and R3: control write and read
        cmd(17, 0, 12'hFF3);
        chk("R4 q flag clear", int'(q), 1);
        chk("R4 gl", int'(gl), 1);
        chk("R4 cont", int'(cont), 1);
        flag = 1'b1;
        stop = 1'b1;
        cmd(1, 0, 0);
        chk("R3 ctrl read", int'(rdata), 12'h033);
        chk("R3 q", int'(q), 1);
        stop = 1'b0;
        flag = 1'b0;
        cmd(1, 0, 0);
        chk("R3 ctrl read flags", int'(rdata), 12'h003);
        cmd(17, 0, 12'h00A);
        flag = 1'b1;
        cmd(1, 0, 0);
        chk("R3 ctrl read second", int'(rdata), 12'h01A);

        // R10: every select against every candidate
        for (int s = 0; s < 4; s++) begin
            cmd(17, 0, s << 2);
            for (int a = 0; a < 4; a++) begin
                cmd(0, a, 0);
                chk($sformatf("R10 sel%0d read a%0d", s, a), int'(restart),
                    ((s == 1 && a == 0) || (s == 2 && a == 1) || (s == 3 && a == 3)) ? 1 : 0);
            end
            cmd(16, 0, 0);
            chk($sformatf("R10 sel%0d cmp write", s), int'(restart), (s == 0) ? 1 : 0);
            @(negedge clk);
            chk("R10 pulse one cycle", int'(restart), 0);
        end
        flag = 1'b0;
        cmd(17, 0, 12'h004);
        cmd(0, 0, 0);
        chk("R10 no restart when q clear", int'(restart), 0);

        // R5: comparator and gain
        flag = 1'b1;
        cmd(16, 0, 12'h5A6);
        chk("R5 q", int'(q), 1);
        chk("R5 cmp", int'(cmp), 12'h5A6);
        chk("R5 gain", int'(gain), 4'h6);
        flag = 1'b0;
        cmd(16, 0, 12'h123);
        chk("R5 refused q", int'(q), 0);
        chk("R5 refused cmp", int'(cmp), 12'h5A6);
        flag = 1'b1;
        cmp_fit = 1'b0;
        cmd(16, 0, 12'hFFF);
        chk("R9 absent comparator x", int'(x), 0);
        chk("R9 absent comparator cmp", int'(cmp), 12'h5A6);
        chk("R9 absent comparator gain", int'(gain), 4'h6);
        cmp_fit = 1'b1;

        // R6: attention
        cmd(27, 0, 0);
        chk("R6 enable test off", int'(q), 0);
        cmd(26, 0, 0);
        chk("R6 enable x", int'(x), 1);
        chk("R6 enable q", int'(q), 0);
        cmd(27, 0, 0);
        chk("R6 enable test on", int'(q), 1);
        #1;
        chk("R6 lam with flag", int'(lam), 1);
        cmd(8, 15, 0);
        chk("R6 test lam set", int'(q), 1);
        flag = 1'b0;
        #1;
        chk("R6 lam no flag", int'(lam), 0);
        cmd(8, 15, 0);
        chk("R6 test lam no flag", int'(q), 0);
        cmd(24, 0, 0);
        chk("R6 disable q", int'(q), 0);
        flag = 1'b1;
        #1;
        chk("R6 lam disabled", int'(lam), 0);

        // R7: broadcast and test mode
        cmd(16, 15, 12'hC3C);
        chk("R7 q", int'(q), 1);
        chk("R7 test mode", int'(test_mode), 1);
        do_store(pattern(7));
        for (int c = 0; c < 4; c++) begin
            cmd(0, c, 0);
            chk("R7 broadcast data", int'(rdata), 12'hC3C);
        end

        // R8: unit reset
        cmd(25, 15, 0);
        chk("R8 x", int'(x), 1);
        chk("R8 q", int'(q), 0);
        chk("R8 pulse", int'(ureset), 1);
        chk("R8 cmp cleared", int'(cmp), 0);
        chk("R8 test cleared", int'(test_mode), 0);
        @(negedge clk);
        chk("R8 pulse ends", int'(ureset), 0);
        pat = pattern(9);
        do_store(pat);
        cmd(0, 1, 0);
        chk("R11 store after test", int'(rdata), int'(pat[23:12]));

        // R9: unfitted channel reads
        chan_fit = 4'b0001;
        cmd(17, 0, 12'h00C);
        cmd(0, 2, 0);
        chk("R9 unfitted x", int'(x), 0);
        chk("R9 unfitted rdata", int'(rdata), 0);
        cmd(0, 3, 0);
        chk("R9 unfitted restart", int'(restart), 0);
        cmd(0, 0, 0);
        chk("R9 fitted still reads", int'(rdata), int'(pat[11:0]));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule